// File: doc/BRIEF.md
# Remapping-Aware Transaction Access Filter

This block sits in the request path of an I/O hub. It classifies each request before the request moves on. Only inbound memory requests go through address remapping. Their guest address is first checked against a programmable guest address width. The request is then sent to an external translation stage over a request/response port. The host address that comes back is checked against the same host address-map rule that applies when remapping is off.

The block also decodes one extra 4 KiB window. The window holds the remapping control registers, and its base is programmable. The window is reachable only from processor-side outbound requests and from sideband management requests, and only with naturally aligned 4-byte or 8-byte accesses. An inbound request that lands in the window is answered with a completer abort.

Each accepted request produces one registered decision: forward, completer abort, unsupported request or address error. The decision comes with the final address. Input and output both use a valid/ready handshake. One request is in flight at a time.

Top module: `remap_filter`

## Requirements
- R1: A request whose kind is not memory (kind codes: 0 memory, 1 I/O, 2 configuration, 3 message) is forwarded (decision code 0) with its address unchanged. This holds whatever the remap-enable, guest-width and window settings are. The translation port is not used, and the decision is valid in the cycle after acceptance.
- R2: When remapping is enabled, an inbound memory request (source code 0, or the reserved code 3, which is treated as inbound) that misses the window is rejected with decision code 3 if any address bit at or above the programmed guest width is set. Such a request is not sent for translation.
- R3: Any other inbound memory request that misses the window, with remapping enabled, is sent to the translation port and stalls until the response arrives. The decision is valid in the cycle after the response is taken. It is code 3 if the host address has any bit at or above HOST_AW set; otherwise it is code 0 with the host address.
- R4: Untranslated memory requests that miss the window get the same host check on their own address (code 3 or code 0 with the address unchanged). These are inbound requests with remapping disabled, and all processor-outbound or sideband requests. The guest width is not applied to them.
- R5: The window covers the 4 KiB block whose upper address bits equal the programmed base. The base is written with cfg_sel = 0 (low 12 bits ignored), the guest width with cfg_sel = 1, and the remap enable with cfg_sel = 2 (bit 0).
- R6: A window access from the processor-outbound source (code 1) or the sideband source (code 2) is forwarded with its address unchanged when its size is 4 or 8 bytes and it is naturally aligned. Size codes are log2 of bytes: 0=1, 1=2, 2=4, 3=8.
- R7: A window access from a permitted source with size 1 or 2 bytes, or with a misaligned address, gets decision code 2 (unsupported request).
- R8: An inbound memory request that hits the window gets decision code 1 (completer abort) and is never translated. This holds whether remapping is on or off, and it takes priority over the guest-width check.
- R9: req_ready is high only when no request is in flight, and stays low while translation is pending. A decision holds its code and address until dec_ready is seen.
- R10: After reset, req_ready is high, dec_valid and xl_req_valid are low, and remapping is disabled. The guest width then equals AW, and the window base is WIN_BASE_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 window base, 1 guest width, 2 remap enable |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_src | input | 2 | Source: 0 inbound, 1 processor outbound, 2 sideband, 3 reserved (as inbound) |
| req_kind | input | 2 | Kind: 0 memory, 1 I/O, 2 configuration, 3 message |
| req_size | input | 2 | log2 of access size in bytes |
| req_addr | input | AW | Request address |
| xl_req_valid | output | 1 | Translation request pending |
| xl_req_addr | output | AW | Guest address to translate |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_addr | input | AW | Translated host address |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Decision taken when high with dec_valid |
| dec_code | output | 2 | 0 forward, 1 completer abort, 2 unsupported request, 3 address error |
| dec_addr | output | AW | Final address |

## Verification
A corrupted window base or guest width shows up as a wrong decision code for the next request near the affected boundary. A base register that does not move, for instance, turns a sub-DWord access to the old window from a forward into an unsupported-request decision. A state machine that skips or repeats the translation wait shows up within a few cycles of acceptance in two ways: a forwarded address that is the guest rather than the host value, or a mismatch between the translations counted and those expected. A decision register that changes while dec_ready is low is caught by the scoreboard, which compares each decision in the cycle it is taken.

// File: rtl/remap_filter_pkg.sv
package remap_filter_pkg;
  typedef enum logic [1:0] {
    SRC_INBOUND  = 2'd0,
    SRC_CPU_OUT  = 2'd1,
    SRC_SIDEBAND = 2'd2,
    SRC_RSVD     = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_IO  = 2'd1,
    KIND_CFG = 2'd2,
    KIND_MSG = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    DEC_FWD = 2'd0,
    DEC_CA  = 2'd1,
    DEC_UR  = 2'd2,
    DEC_ERR = 2'd3
  } dec_e;

  typedef enum logic [1:0] {
    CFG_SEL_BASE = 2'd0,
    CFG_SEL_GAW  = 2'd1,
    CFG_SEL_CTRL = 2'd2,
    CFG_SEL_RSVD = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_OUT   = 2'd2
  } state_e;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_filter_pkg::*;
#(
  parameter int AW           = 40,
  parameter int WIN_BITS     = 12,
  parameter logic [AW-1:0] WIN_BASE_RST = 40'h00FED90000,
  localparam int GW          = $clog2(AW + 1),
  localparam int TW          = AW - WIN_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [TW-1:0] win_tag,
  output logic [GW-1:0] gaw,
  output logic          remap_en
);
  localparam logic [GW-1:0] GAW_RST = GW'(AW);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_tag  <= WIN_BASE_RST[AW-1:WIN_BITS];
      gaw      <= GAW_RST;
      remap_en <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        CFG_SEL_BASE: win_tag  <= wdata[AW-1:WIN_BITS];
        CFG_SEL_GAW:  gaw      <= wdata[GW-1:0];
        CFG_SEL_CTRL: remap_en <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/remap_window_check.sv
module remap_window_check #(
  parameter int AW       = 40,
  parameter int WIN_BITS = 12,
  localparam int TW      = AW - WIN_BITS
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [TW-1:0] win_tag,
  output logic          hit,
  output logic          access_ok
);
  logic aligned;

  assign hit = (addr[AW-1:WIN_BITS] == win_tag);

  always_comb begin
    case (size)
      2'd2:    aligned = (addr[1:0] == 2'b00);
      2'd3:    aligned = (addr[2:0] == 3'b000);
      default: aligned = 1'b0;
    endcase
  end

  assign access_ok = size[1] && aligned;
endmodule

// File: rtl/remap_host_check.sv
module remap_host_check #(
  parameter int AW      = 40,
  parameter int HOST_AW = 36
) (
  input  logic [AW-1:0] addr,
  output logic          ok
);
  generate
    if (HOST_AW >= AW) begin : g_full
      assign ok = 1'b1;
    end else begin : g_limited
      assign ok = (addr[AW-1:HOST_AW] == '0);
    end
  endgenerate
endmodule

// File: rtl/remap_filter.sv
module remap_filter
  import remap_filter_pkg::*;
#(
  parameter int AW       = 40,
  parameter int HOST_AW  = 36,
  parameter int WIN_BITS = 12,
  parameter logic [AW-1:0] WIN_BASE_RST = 40'h00FED90000,
  localparam int GW      = $clog2(AW + 1),
  localparam int TW      = AW - WIN_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_src,
  input  logic [1:0]    req_kind,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  output logic          xl_req_valid,
  output logic [AW-1:0] xl_req_addr,
  input  logic          xl_rsp_valid,
  input  logic [AW-1:0] xl_rsp_addr,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [1:0]    dec_code,
  output logic [AW-1:0] dec_addr
);
  logic [TW-1:0] win_tag;
  logic [GW-1:0] gaw;
  logic          remap_en;
  logic          win_hit, win_ok, raw_host_ok, xl_host_ok, guest_ok;
  logic          is_inbound, need_xlate;
  dec_e          nxt_code;
  state_e        state;

  remap_cfg_regs #(.AW(AW), .WIN_BITS(WIN_BITS), .WIN_BASE_RST(WIN_BASE_RST)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .win_tag(win_tag), .gaw(gaw), .remap_en(remap_en)
  );

  remap_window_check #(.AW(AW), .WIN_BITS(WIN_BITS)) win_i (
    .addr(req_addr), .size(req_size), .win_tag(win_tag),
    .hit(win_hit), .access_ok(win_ok)
  );

  remap_host_check #(.AW(AW), .HOST_AW(HOST_AW)) raw_host_i (
    .addr(req_addr), .ok(raw_host_ok)
  );

  remap_host_check #(.AW(AW), .HOST_AW(HOST_AW)) xl_host_i (
    .addr(xl_rsp_addr), .ok(xl_host_ok)
  );

  assign guest_ok   = ((req_addr >> gaw) == '0);
  assign is_inbound = (src_e'(req_src) == SRC_INBOUND) || (src_e'(req_src) == SRC_RSVD);
  assign req_ready  = (state == ST_IDLE);

  // Classification of the presented request, in priority order.
  always_comb begin
    need_xlate = 1'b0;
    nxt_code   = DEC_FWD;
    if (kind_e'(req_kind) != KIND_MEM) begin
      nxt_code = DEC_FWD;
    end else if (win_hit) begin
      if (is_inbound)   nxt_code = DEC_CA;
      else if (win_ok)  nxt_code = DEC_FWD;
      else              nxt_code = DEC_UR;
    end else if (is_inbound && remap_en) begin
      if (!guest_ok) nxt_code = DEC_ERR;
      else           need_xlate = 1'b1;
    end else begin
      nxt_code = raw_host_ok ? DEC_FWD : DEC_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      xl_req_valid <= 1'b0;
      xl_req_addr  <= '0;
      dec_valid    <= 1'b0;
      dec_code     <= DEC_FWD;
      dec_addr     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (need_xlate) begin
              xl_req_valid <= 1'b1;
              xl_req_addr  <= req_addr;
              state        <= ST_XLATE;
            end else begin
              dec_code  <= nxt_code;
              dec_addr  <= req_addr;
              dec_valid <= 1'b1;
              state     <= ST_OUT;
            end
          end
        end
        ST_XLATE: begin
          if (xl_rsp_valid) begin
            xl_req_valid <= 1'b0;
            dec_code     <= xl_host_ok ? DEC_FWD : DEC_ERR;
            dec_addr     <= xl_rsp_addr;
            dec_valid    <= 1'b1;
            state        <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (dec_ready) begin
            dec_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/remap_filter_chk.sv
module remap_filter_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [AW-1:0] req_addr,
  input logic          xl_req_valid,
  input logic          xl_rsp_valid,
  input logic [AW-1:0] xl_rsp_addr,
  input logic          dec_valid,
  input logic          dec_ready,
  input logic [1:0]    dec_code,
  input logic [AW-1:0] dec_addr
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_code) && $stable(dec_addr));

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    xl_req_valid |-> !req_ready && !dec_valid);

  assert_nonmem_fwd_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_kind != 2'd0)
      |=> dec_valid && (dec_code == 2'd0) && (dec_addr == $past(req_addr)));

  assert_xlate_result_R3: assert property (@(posedge clk) disable iff (rst)
    xl_req_valid && xl_rsp_valid
      |=> dec_valid && !xl_req_valid && (dec_addr == $past(xl_rsp_addr)));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !req_ready);
endmodule

bind remap_filter remap_filter_chk #(.AW(AW)) chk_i (.*);

// File: tb/remap_filter_tb_top.sv
module remap_filter_tb_top;
  localparam int AW = 40;
  localparam logic [AW-1:0] OLD_BASE = 40'h00FED90000;
  localparam logic [AW-1:0] NEW_BASE = 40'h0012345000;
  localparam logic [AW-1:0] XL_OFS   = 40'h00F0000000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_src = '0, req_kind = '0, req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic          xl_req_valid;
  logic [AW-1:0] xl_req_addr;
  logic          xl_rsp_valid = 1'b0;
  logic [AW-1:0] xl_rsp_addr = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [1:0]    dec_code;
  logic [AW-1:0] dec_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int n_xlate  = 0;
  logic [AW+1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  remap_filter dut_i (.*);

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input string req, input logic [1:0] src, input logic [1:0] kind,
                      input logic [1:0] size, input logic [AW-1:0] addr,
                      input logic [1:0] ecode, input logic [AW-1:0] eaddr);
    exp_q.push_back({ecode, eaddr});
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_kind = kind; req_size = size; req_addr = addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Translation responder: fixed offset mapping, three-cycle latency.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && xl_req_valid) begin
        n_xlate++;
        for (int i = 0; i < 3; i++) begin
          check(!req_ready && !dec_valid, "R9", $sformatf("ready=%0b", req_ready), "ready=0 during translation");
          @(negedge clk);
        end
        xl_rsp_valid = 1'b1;
        xl_rsp_addr  = xl_req_addr + XL_OFS;
        @(negedge clk);
        xl_rsp_valid = 1'b0;
      end
    end
  end

  // Output back-pressure pattern.
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #2;
      dec_ready = (k % 3) != 1;
      k++;
    end
  end

  // Monitor: pop and compare each decision as it is taken.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && dec_valid && dec_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", $sformatf("code=%0d addr=%h", dec_code, dec_addr), "no decision");
        end else begin
          logic [AW+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({dec_code, dec_addr} == e, t,
                $sformatf("code=%0d addr=%h", dec_code, dec_addr),
                $sformatf("code=%0d addr=%h", e[AW+1:AW], e[AW-1:0]));
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !dec_valid && !xl_req_valid, "R10",
              $sformatf("rdy=%0b dv=%0b xv=%0b", req_ready, dec_valid, xl_req_valid), "rdy=1 dv=0 xv=0");
        // Defaults: remap off, gaw 40, base OLD_BASE
        send("R1",  2'd0, 2'd1, 2'd2, 40'h0000001234, 2'd0, 40'h0000001234);
        send("R1",  2'd0, 2'd1, 2'd2, OLD_BASE + 40'h10, 2'd0, OLD_BASE + 40'h10);
        send("R4",  2'd0, 2'd0, 2'd2, 40'h0000002000, 2'd0, 40'h0000002000);
        send("R4",  2'd0, 2'd0, 2'd2, 40'h1000000000, 2'd3, 40'h1000000000);
        send("R8",  2'd0, 2'd0, 2'd2, OLD_BASE + 40'h10, 2'd1, OLD_BASE + 40'h10);
        send("R8",  2'd3, 2'd0, 2'd3, OLD_BASE + 40'h18, 2'd1, OLD_BASE + 40'h18);
        send("R6",  2'd1, 2'd0, 2'd3, OLD_BASE + 40'h8, 2'd0, OLD_BASE + 40'h8);
        send("R6",  2'd1, 2'd0, 2'd2, OLD_BASE + 40'h4, 2'd0, OLD_BASE + 40'h4);
        send("R6",  2'd2, 2'd0, 2'd2, OLD_BASE + 40'h20, 2'd0, OLD_BASE + 40'h20);
        send("R7",  2'd1, 2'd0, 2'd3, OLD_BASE + 40'h4, 2'd2, OLD_BASE + 40'h4);
        send("R7",  2'd2, 2'd0, 2'd2, OLD_BASE + 40'h1, 2'd2, OLD_BASE + 40'h1);
        send("R7",  2'd1, 2'd0, 2'd1, OLD_BASE, 2'd2, OLD_BASE);
        // Reprogram: new base, guest width 39, remap on
        cfg_write(2'd0, NEW_BASE + 40'h0ABC);
        cfg_write(2'd1, 40'd39);
        cfg_write(2'd2, 40'd1);
        send("R5",  2'd1, 2'd0, 2'd0, OLD_BASE, 2'd0, OLD_BASE);
        send("R5",  2'd1, 2'd0, 2'd0, NEW_BASE + 40'h40, 2'd2, NEW_BASE + 40'h40);
        send("R8",  2'd0, 2'd0, 2'd2, NEW_BASE, 2'd1, NEW_BASE);
        send("R2",  2'd0, 2'd0, 2'd2, 40'h8000000000, 2'd3, 40'h8000000000);
        send("R3",  2'd0, 2'd0, 2'd2, 40'h0010000000, 2'd0, 40'h0100000000);
        send("R3",  2'd0, 2'd0, 2'd2, 40'h0F10000000, 2'd3, 40'h1000000000);
        send("R1",  2'd0, 2'd2, 2'd2, 40'h8000000000, 2'd0, 40'h8000000000);
        send("R4",  2'd2, 2'd0, 2'd2, 40'h0000005000, 2'd0, 40'h0000005000);
        // Narrow guest width: window abort wins over the guest check
        cfg_write(2'd1, 40'd20);
        send("R8",  2'd0, 2'd0, 2'd2, NEW_BASE + 40'h8, 2'd1, NEW_BASE + 40'h8);
        send("R2",  2'd0, 2'd0, 2'd2, 40'h0000100000, 2'd3, 40'h0000100000);
        // Remap off: guest width no longer applied
        cfg_write(2'd2, 40'd0);
        send("R4",  2'd0, 2'd0, 2'd2, 40'h0000200000, 2'd0, 40'h0000200000);
        while (exp_q.size() != 0 || dec_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        check(n_xlate == 2, "R3", $sformatf("%0d translations", n_xlate), "2 translations");
      end
      begin
        repeat (20000) @(negedge clk);
        check(1'b0, "R9", "watchdog expired", "run completes");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule